// File: doc/BRIEF.md
# Programmable Packet Deparser

The deparser rebuilds an outgoing packet at the end of a match-action pipeline. It first stores the original packet as it arrives in 64-bit chunks, together with the packet's metadata: its original length and the start offset of each header. It then takes the final header vector (a set of 32-bit slots) and writes header fields from the vector back into the stored packet. Every byte that no field covers keeps its original value. The rebuilt packet leaves as a stream of 64-bit chunks, marked with start and end, and the last chunk carries a byte count.

Fields are placed by a table of descriptors, written through a configuration port. The descriptor format is the same one the parser uses to extract fields, so one configuration image serves both ends of the pipeline. Each descriptor names a header, a byte offset inside that header, a field width of 1 to 4 bytes and a vector slot. The descriptor is applied only if the vector marks that header as present. Slot 0 of the vector is reserved: it carries the output length and the header-present bits. The block does not insert or remove headers, and it does not recompute checksums.

Top module: `pkt_deparser`

## Requirements
- R1: After reset, outValid is 0, pktInReady is 1, phvReady is 0, and every descriptor is disabled.
- R2: Byte i of the packet is carried in chunk i/8, in lane i%8, and lane 0 sits in bits [63:56]. Only bytes with index below metaLen (taken with the first chunk) and below MAX_BYTES are stored. Every other byte position of the buffer reads back as zero.
- R3: When cfgWrEn is high, entry cfgIdx is written with cfgDesc. The fields of cfgDesc are: [15] enable, [14:13] header id, [12:5] byte offset inside the header, [4:3] width in bytes minus one, [2:0] slot index. The offset of header h is metaHdrOff[8h+7:8h].
- R4: For an enabled descriptor whose header is present, the output bytes at headerOffset+offset+j, for j = 0 to width-1, take the low width bytes of the slot, most significant byte first. Any of these bytes that falls at or beyond MAX_BYTES is dropped.
- R5: A descriptor with enable 0, or one whose header-present bit is 0, leaves the original bytes unchanged.
- R6: Descriptors are applied in ascending index order. Where two fields overlap, the higher index wins.
- R7: The output length is phvData[15:0]. A value of 0 is treated as 1, and a value above MAX_BYTES is treated as MAX_BYTES. The present bit of header h is phvData[16+h].
- R8: Output chunks run from index 0 upward. outStart is set on the first chunk and outEnd on the last. outBytes is 8 on every chunk except the last, which carries the remainder (1 to 8), and lanes past that count are zero. After the last chunk is accepted, outValid falls.
- R9: While outValid is high and outReady is low, the presented chunk and its markers stay unchanged, so no chunk is lost or repeated.
- R10: Packet chunks are accepted only before the vector is accepted. phvReady rises only after the chunk marked last has been accepted. The first output chunk appears NUM_DESC cycles after the vector is accepted, and pktInReady returns once the last output chunk has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Descriptor write strobe |
| cfgIdx | input | $clog2(NUM_DESC) | Descriptor entry to write |
| cfgDesc | input | 16 | Descriptor contents |
| pktInValid | input | 1 | Original-packet chunk valid |
| pktInReady | output | 1 | Deparser accepts packet chunks |
| pktInData | input | 8*CHUNK_BYTES | Original-packet chunk |
| pktInLast | input | 1 | Marks the last chunk of the packet |
| metaLen | input | 16 | Original byte length, taken with the first chunk |
| metaHdrOff | input | 32 | Four header start offsets, taken with the first chunk |
| phvValid | input | 1 | Header vector valid |
| phvReady | output | 1 | Deparser accepts the header vector |
| phvData | input | 256 | Eight 32-bit slots, slot s in bits [32s+31:32s] |
| outValid | output | 1 | Output chunk valid |
| outReady | input | 1 | Downstream accepts the output chunk |
| outData | output | 8*CHUNK_BYTES | Output chunk |
| outStart | output | 1 | First chunk of the packet |
| outEnd | output | 1 | Last chunk of the packet |
| outBytes | output | $clog2(CHUNK_BYTES+1) | Number of valid bytes in the chunk |

## Verification
The bench uses the default parameters: 8-byte chunks, a 64-byte buffer and 8 descriptors. With these values, a packet of 10 chunks overruns the buffer, and lengths of 0 and above 64 both reach the clamp. A header at offset 60 pushes fields past the buffer end. Random descriptor tables with header offsets up to 40 make fields overlap often enough to exercise the write order. A randomly stalling ready signal exercises the hold behaviour on every chunk position, including the last.

// File: rtl/deparse_pkg.sv
package deparse_pkg;

  // descriptor format shared with the extraction side
  localparam int SLOT_BYTES = 4;
  localparam int NUM_SLOTS  = 8;
  localparam int NUM_HDR    = 4;
  localparam int HDR_ID_W   = $clog2(NUM_HDR);
  localparam int SLOT_ID_W  = $clog2(NUM_SLOTS);
  localparam int OFF_W      = 8;
  localparam int WID_W      = $clog2(SLOT_BYTES);
  localparam int PHV_W      = NUM_SLOTS * SLOT_BYTES * 8;
  localparam int LEN_W      = 16;
  localparam int PRESENT_LSB = LEN_W;

  typedef struct packed {
    logic                 en;
    logic [HDR_ID_W-1:0]  hdrId;
    logic [OFF_W-1:0]     byteOff;
    logic [WID_W-1:0]     widthM1;
    logic [SLOT_ID_W-1:0] slotId;
  } fieldDesc_t;

  localparam int DESC_W = $bits(fieldDesc_t);

  // strobes from control to datapath
  typedef struct packed {
    logic clearBuf;
    logic loadChunk;
    logic capMeta;
    logic capPhv;
    logic patchEn;
  } dpStrobe_t;

endpackage

// File: rtl/deparse_desc_table.sv
module deparse_desc_table
  import deparse_pkg::*;
#(
  parameter int NUM_DESC = 8,
  parameter int DIDX_W   = $clog2(NUM_DESC)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DIDX_W-1:0] wrIdx,
  input  logic [DESC_W-1:0] wrDesc,
  input  logic [DIDX_W-1:0] rdIdx,
  output fieldDesc_t        rdDesc
);

  logic [DESC_W-1:0] entry [NUM_DESC];

  for (genvar g = 0; g < NUM_DESC; g++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entry[g] <= '0;
      end else if (wrEn && (wrIdx == DIDX_W'(g))) begin
        entry[g] <= wrDesc;
      end
    end
  end

  assign rdDesc = fieldDesc_t'(entry[rdIdx]);

endmodule

// File: rtl/deparse_ctrl.sv
module deparse_ctrl
  import deparse_pkg::*;
#(
  parameter int NUM_DESC = 8,
  parameter int NCHUNK   = 8,
  parameter int DIDX_W   = $clog2(NUM_DESC),
  parameter int CIDX_W   = $clog2(NCHUNK),
  parameter int CCNT_W   = $clog2(NCHUNK + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pktInValid,
  input  logic              pktInLast,
  output logic              pktInReady,
  input  logic              phvValid,
  output logic              phvReady,
  input  logic              outReady,
  input  logic              emitLast,
  output logic              outValid,
  output logic              outStart,
  output logic              outEnd,
  output dpStrobe_t         strobe,
  output logic [CCNT_W-1:0] chunkCnt,
  output logic [DIDX_W-1:0] descIdx,
  output logic [CIDX_W-1:0] emitIdx
);

  typedef enum logic [1:0] {sLoad, sWaitPhv, sPatch, sEmit} state_t;
  state_t state;

  logic inFire;

  assign pktInReady = (state == sLoad);
  assign phvReady   = (state == sWaitPhv);
  assign outValid   = (state == sEmit);
  assign outStart   = outValid && (emitIdx == '0);
  assign outEnd     = outValid && emitLast;
  assign inFire     = pktInValid && pktInReady;

  always_comb begin
    strobe           = '0;
    strobe.loadChunk = inFire;
    strobe.clearBuf  = inFire && (chunkCnt == '0);
    strobe.capMeta   = inFire && (chunkCnt == '0);
    strobe.capPhv    = phvValid && phvReady;
    strobe.patchEn   = (state == sPatch);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= sLoad;
      chunkCnt <= '0;
      descIdx  <= '0;
      emitIdx  <= '0;
    end else begin
      case (state)
        sLoad: begin
          if (inFire) begin
            if (pktInLast) begin
              chunkCnt <= '0;
              state    <= sWaitPhv;
            end else if (chunkCnt != CCNT_W'(NCHUNK)) begin
              chunkCnt <= chunkCnt + 1'b1;
            end
          end
        end
        sWaitPhv: begin
          if (phvValid) begin
            descIdx <= '0;
            state   <= sPatch;
          end
        end
        sPatch: begin
          if (descIdx == DIDX_W'(NUM_DESC - 1)) begin
            emitIdx <= '0;
            state   <= sEmit;
          end else begin
            descIdx <= descIdx + 1'b1;
          end
        end
        sEmit: begin
          if (outReady) begin
            if (emitLast) state <= sLoad;
            else          emitIdx <= emitIdx + 1'b1;
          end
        end
        default: state <= sLoad;
      endcase
    end
  end

  // R9
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(emitIdx) && $stable(outEnd)));

  // R8
  first_is_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> outStart);

  // R8
  end_drops_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outEnd) |=> (!outValid && pktInReady));

  // R10
  phv_then_patch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phvValid && phvReady) |=> (!outValid && !pktInReady && !phvReady));

endmodule

// File: rtl/deparse_datapath.sv
module deparse_datapath
  import deparse_pkg::*;
#(
  parameter int CHUNK_BYTES = 8,
  parameter int MAX_BYTES   = 64,
  parameter int NCHUNK      = MAX_BYTES / CHUNK_BYTES,
  parameter int CIDX_W      = $clog2(NCHUNK),
  parameter int CCNT_W      = $clog2(NCHUNK + 1),
  parameter int CNT_W       = $clog2(CHUNK_BYTES + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpStrobe_t                strobe,
  input  logic [CCNT_W-1:0]        chunkCnt,
  input  logic [8*CHUNK_BYTES-1:0] inData,
  input  logic [LEN_W-1:0]         metaLenIn,
  input  logic [8*NUM_HDR-1:0]     metaHdrOffIn,
  input  logic [PHV_W-1:0]         phvIn,
  input  fieldDesc_t               desc,
  input  logic [CIDX_W-1:0]        emitIdx,
  output logic                     emitLast,
  output logic [8*CHUNK_BYTES-1:0] outData,
  output logic [CNT_W-1:0]         outBytes
);

  localparam int BIDX_W = $clog2(MAX_BYTES);

  logic [7:0]           bufMem [MAX_BYTES];
  logic [LEN_W-1:0]     lenReg;
  logic [8*NUM_HDR-1:0] hdrOffReg;
  logic [PHV_W-1:0]     phvReg;

  // load-side byte placement
  logic [LEN_W-1:0] lenForWrite;
  logic [31:0]      loadPos [CHUNK_BYTES];
  logic             loadOk  [CHUNK_BYTES];
  logic [7:0]       loadByte[CHUNK_BYTES];

  assign lenForWrite = strobe.capMeta ? metaLenIn : lenReg;

  always_comb begin
    for (int k = 0; k < CHUNK_BYTES; k++) begin
      loadPos[k]  = 32'(chunkCnt) * 32'(CHUNK_BYTES) + 32'(k);
      loadOk[k]   = (loadPos[k] < 32'(MAX_BYTES)) && (loadPos[k] < 32'(lenForWrite));
      loadByte[k] = inData[8*(CHUNK_BYTES-1-k) +: 8];
    end
  end

  // patch-side byte placement
  logic [7:0]  hdrBase;
  logic        hdrPresent;
  logic        fieldLive;
  logic [31:0] slotVal;
  logic [31:0] patchPos [SLOT_BYTES];
  logic        patchOk  [SLOT_BYTES];
  logic [7:0]  patchByte[SLOT_BYTES];

  always_comb begin
    hdrBase    = hdrOffReg[8*desc.hdrId +: 8];
    hdrPresent = phvReg[PRESENT_LSB + int'(desc.hdrId)];
    fieldLive  = strobe.patchEn && desc.en && hdrPresent;
    slotVal    = phvReg[32*desc.slotId +: 32];
    for (int j = 0; j < SLOT_BYTES; j++) begin
      patchPos[j]  = 32'(hdrBase) + 32'(desc.byteOff) + 32'(j);
      patchOk[j]   = fieldLive && (j <= int'(desc.widthM1)) &&
                     (patchPos[j] < 32'(MAX_BYTES));
      patchByte[j] = 8'(slotVal >> (8 * ((j <= int'(desc.widthM1)) ?
                                         (int'(desc.widthM1) - j) : 0)));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenReg    <= '0;
      hdrOffReg <= '0;
      phvReg    <= '0;
      for (int i = 0; i < MAX_BYTES; i++) bufMem[i] <= '0;
    end else begin
      if (strobe.capMeta) begin
        lenReg    <= metaLenIn;
        hdrOffReg <= metaHdrOffIn;
      end
      if (strobe.capPhv) phvReg <= phvIn;
      if (strobe.clearBuf) begin
        for (int i = 0; i < MAX_BYTES; i++) bufMem[i] <= '0;
      end
      if (strobe.loadChunk) begin
        for (int k = 0; k < CHUNK_BYTES; k++) begin
          if (loadOk[k]) bufMem[loadPos[k][BIDX_W-1:0]] <= loadByte[k];
        end
      end
      for (int j = 0; j < SLOT_BYTES; j++) begin
        if (patchOk[j]) bufMem[patchPos[j][BIDX_W-1:0]] <= patchByte[j];
      end
    end
  end

  // length decode and chunk emission
  logic [31:0] rawLen, effLen, numChunks, lastCount, laneCount;
  logic [31:0] rdPos [CHUNK_BYTES];

  always_comb begin
    rawLen    = 32'(phvReg[LEN_W-1:0]);
    if (rawLen == 0)                    effLen = 32'd1;
    else if (rawLen > 32'(MAX_BYTES))   effLen = 32'(MAX_BYTES);
    else                                effLen = rawLen;
    numChunks = (effLen + 32'(CHUNK_BYTES) - 1) / 32'(CHUNK_BYTES);
    lastCount = effLen - (numChunks - 1) * 32'(CHUNK_BYTES);
    emitLast  = (32'(emitIdx) == numChunks - 1);
    laneCount = emitLast ? lastCount : 32'(CHUNK_BYTES);
    outBytes  = CNT_W'(laneCount);
    for (int k = 0; k < CHUNK_BYTES; k++) begin
      rdPos[k] = 32'(emitIdx) * 32'(CHUNK_BYTES) + 32'(k);
      outData[8*(CHUNK_BYTES-1-k) +: 8] =
        (32'(k) < laneCount) ? bufMem[rdPos[k][BIDX_W-1:0]] : 8'h00;
    end
  end

  // R7
  chunk_count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (numChunks >= 1) && (numChunks <= 32'(NCHUNK)));

endmodule

// File: rtl/pkt_deparser.sv
module pkt_deparser
  import deparse_pkg::*;
#(
  parameter int CHUNK_BYTES = 8,
  parameter int MAX_BYTES   = 64,
  parameter int NUM_DESC    = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cfgWrEn,
  input  logic [$clog2(NUM_DESC)-1:0]   cfgIdx,
  input  logic [DESC_W-1:0]             cfgDesc,
  input  logic                          pktInValid,
  output logic                          pktInReady,
  input  logic [8*CHUNK_BYTES-1:0]      pktInData,
  input  logic                          pktInLast,
  input  logic [LEN_W-1:0]              metaLen,
  input  logic [8*NUM_HDR-1:0]          metaHdrOff,
  input  logic                          phvValid,
  output logic                          phvReady,
  input  logic [PHV_W-1:0]              phvData,
  output logic                          outValid,
  input  logic                          outReady,
  output logic [8*CHUNK_BYTES-1:0]      outData,
  output logic                          outStart,
  output logic                          outEnd,
  output logic [$clog2(CHUNK_BYTES+1)-1:0] outBytes
);

  localparam int NCHUNK = MAX_BYTES / CHUNK_BYTES;
  localparam int DIDX_W = $clog2(NUM_DESC);
  localparam int CIDX_W = $clog2(NCHUNK);
  localparam int CCNT_W = $clog2(NCHUNK + 1);
  localparam int CNT_W  = $clog2(CHUNK_BYTES + 1);

  dpStrobe_t         strobe;
  logic [CCNT_W-1:0] chunkCnt;
  logic [DIDX_W-1:0] descIdx;
  logic [CIDX_W-1:0] emitIdx;
  logic              emitLast;
  fieldDesc_t        curDesc;

  deparse_desc_table #(.NUM_DESC(NUM_DESC), .DIDX_W(DIDX_W)) descTable_i (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (cfgWrEn),
    .wrIdx (cfgIdx),
    .wrDesc(cfgDesc),
    .rdIdx (descIdx),
    .rdDesc(curDesc)
  );

  deparse_ctrl #(
    .NUM_DESC(NUM_DESC), .NCHUNK(NCHUNK),
    .DIDX_W(DIDX_W), .CIDX_W(CIDX_W), .CCNT_W(CCNT_W)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .pktInValid(pktInValid),
    .pktInLast (pktInLast),
    .pktInReady(pktInReady),
    .phvValid  (phvValid),
    .phvReady  (phvReady),
    .outReady  (outReady),
    .emitLast  (emitLast),
    .outValid  (outValid),
    .outStart  (outStart),
    .outEnd    (outEnd),
    .strobe    (strobe),
    .chunkCnt  (chunkCnt),
    .descIdx   (descIdx),
    .emitIdx   (emitIdx)
  );

  deparse_datapath #(
    .CHUNK_BYTES(CHUNK_BYTES), .MAX_BYTES(MAX_BYTES), .NCHUNK(NCHUNK),
    .CIDX_W(CIDX_W), .CCNT_W(CCNT_W), .CNT_W(CNT_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .chunkCnt    (chunkCnt),
    .inData      (pktInData),
    .metaLenIn   (metaLen),
    .metaHdrOffIn(metaHdrOff),
    .phvIn       (phvData),
    .desc        (curDesc),
    .emitIdx     (emitIdx),
    .emitLast    (emitLast),
    .outData     (outData),
    .outBytes    (outBytes)
  );

  // R8
  byte_count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((outBytes != '0) && (outBytes <= CNT_W'(CHUNK_BYTES)) &&
                  (outEnd || (outBytes == CNT_W'(CHUNK_BYTES)))));

endmodule

// File: tb/pkt_deparser_tb_top.sv
module pkt_deparser_tb_top;

  localparam int CB   = 8;
  localparam int MAXB = 64;
  localparam int ND   = 8;
  localparam int NH   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic          cfgWrEn = 0;
  logic [2:0]    cfgIdx = 0;
  logic [15:0]   cfgDesc = 0;
  logic          pktInValid = 0;
  logic          pktInReady;
  logic [63:0]   pktInData = 0;
  logic          pktInLast = 0;
  logic [15:0]   metaLen = 0;
  logic [31:0]   metaHdrOff = 0;
  logic          phvValid = 0;
  logic          phvReady;
  logic [255:0]  phvData = 0;
  logic          outValid;
  logic          outReady = 0;
  logic [63:0]   outData;
  logic          outStart;
  logic          outEnd;
  logic [3:0]    outBytes;

  pkt_deparser dut_i (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgIdx(cfgIdx), .cfgDesc(cfgDesc),
    .pktInValid(pktInValid), .pktInReady(pktInReady), .pktInData(pktInData),
    .pktInLast(pktInLast), .metaLen(metaLen), .metaHdrOff(metaHdrOff),
    .phvValid(phvValid), .phvReady(phvReady), .phvData(phvData),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .outStart(outStart), .outEnd(outEnd), .outBytes(outBytes)
  );

  int checks = 0;
  int errors = 0;

  logic [15:0] descM  [ND];
  logic [7:0]  srcB   [128];
  logic [7:0]  expM   [MAXB];
  logic [7:0]  hdrOffM[NH];
  logic [31:0] slotM  [8];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeDesc(input int idx, input logic [15:0] val);
    @(negedge clk);
    cfgWrEn = 1; cfgIdx = 3'(idx); cfgDesc = val;
    @(negedge clk);
    cfgWrEn = 0;
    descM[idx] = val;
  endtask

  function automatic logic [15:0] mkDesc(input bit en, input int h, input int off,
                                         input int w, input int slot);
    return {en, 2'(h), 8'(off), 2'(w - 1), 3'(slot)};
  endfunction

  // build the expected buffer; returns the effective length
  function automatic int model(input int nChunks, input int mLen, input logic [3:0] present,
                               input int pktLen);
    int eff;
    for (int i = 0; i < MAXB; i++) expM[i] = 8'h00;
    for (int i = 0; i < nChunks * CB; i++)
      if (i < MAXB && i < mLen) expM[i] = srcB[i];
    for (int d = 0; d < ND; d++) begin
      logic [15:0] dd = descM[d];
      int h = int'(dd[14:13]);
      int off = int'(dd[12:5]);
      int w = int'(dd[4:3]) + 1;
      int s = int'(dd[2:0]);
      if (dd[15] && present[h]) begin
        for (int j = 0; j < w; j++) begin
          int p = int'(hdrOffM[h]) + off + j;
          if (p < MAXB) expM[p] = 8'(slotM[s] >> (8 * (w - 1 - j)));
        end
      end
    end
    eff = (pktLen == 0) ? 1 : (pktLen > MAXB) ? MAXB : pktLen;
    return eff;
  endfunction

  function automatic logic [63:0] expChunk(input int idx, input int cnt);
    logic [63:0] v = '0;
    for (int k = 0; k < CB; k++)
      if (k < cnt) v[8*(CB-1-k) +: 8] = expM[idx*CB + k];
    return v;
  endfunction

  task automatic runPacket(input int nChunks, input int mLen, input int pktLen,
                           input logic [3:0] present, input string tag);
    int eff, nExp, idx, w, guard, cnt;
    bit done, prevStall;
    logic [63:0] prevData;
    for (int i = 0; i < 128; i++) srcB[i] = 8'($urandom);
    slotM[0] = {12'h000, present, 16'(pktLen)};
    eff  = model(nChunks, mLen, present, pktLen);
    nExp = (eff + CB - 1) / CB;
    // load the original packet
    for (int c = 0; c < nChunks; ) begin
      @(negedge clk);
      if ($urandom % 4 == 0) begin
        pktInValid = 0;
      end else begin
        pktInValid = 1;
        for (int k = 0; k < CB; k++) pktInData[8*(CB-1-k) +: 8] = srcB[c*CB + k];
        pktInLast  = (c == nChunks - 1);
        metaLen    = 16'(mLen);
        metaHdrOff = {hdrOffM[3], hdrOffM[2], hdrOffM[1], hdrOffM[0]};
        chk("R10 phvReady low while loading", 64'(phvReady), 64'd0);
        if (pktInReady) c++;
      end
    end
    @(negedge clk);
    pktInValid = 0; pktInLast = 0;
    // header vector
    for (int s = 0; s < 8; s++) phvData[32*s +: 32] = slotM[s];
    phvValid = 1;
    chk("R10 phvReady after last chunk", 64'(phvReady), 64'd1);
    chk("R10 pktInReady low after last chunk", 64'(pktInReady), 64'd0);
    @(negedge clk);
    phvValid = 0;
    w = 0;
    while (!outValid && w < 100) begin w++; @(negedge clk); end
    chk("R10 output latency", 64'(w), 64'(ND));
    // collect
    idx = 0; done = 0; prevStall = 0; prevData = '0; guard = 0;
    while (!done && guard < 1000) begin
      guard++;
      if (!outValid) begin
        chk("R8 outValid dropped mid-packet", 64'(outValid), 64'd1);
        break;
      end
      cnt = (idx == nExp - 1) ? (eff - (nExp - 1) * CB) : CB;
      chk(tag, outData, expChunk(idx, cnt));
      chk("R8 outStart", 64'(outStart), 64'(idx == 0));
      chk("R8 outEnd", 64'(outEnd), 64'(idx == nExp - 1));
      chk("R8 outBytes", 64'(outBytes), 64'(cnt));
      if (prevStall) chk("R9 chunk held under stall", outData, prevData);
      prevData  = outData;
      prevStall = ($urandom % 3 == 0);
      outReady  = !prevStall;
      if (outReady) begin
        if (idx == nExp - 1) done = 1;
        idx++;
      end
      @(negedge clk);
    end
    outReady = 0;
    chk("R8 outValid low after end", 64'(outValid), 64'd0);
    chk("R10 pktInReady back after end", 64'(pktInReady), 64'd1);
  endtask

  task automatic clearDescs();
    for (int d = 0; d < ND; d++) writeDesc(d, 16'h0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int d = 0; d < ND; d++) descM[d] = '0;
    for (int s = 0; s < 8; s++) slotM[s] = '0;
    for (int h = 0; h < NH; h++) hdrOffM[h] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 outValid", 64'(outValid), 64'd0);
    chk("R1 pktInReady", 64'(pktInReady), 64'd1);
    chk("R1 phvReady", 64'(phvReady), 64'd0);
    rstN = 1;
    @(negedge clk);
    // R1: descriptors disabled after reset, packet passes through unchanged
    hdrOffM[0] = 8'd0;
    runPacket(2, 16, 16, 4'hF, "R1 descriptors disabled after reset");

    // R3 / R4: single field, big-endian placement
    hdrOffM[1] = 8'd10;
    slotM[2] = 32'hA1B2C3D4;
    writeDesc(0, mkDesc(1, 1, 3, 4, 2));
    runPacket(4, 32, 32, 4'b0010, "R3 R4 field overwrite");

    // R6: overlapping field at higher index wins
    slotM[3] = 32'h1234EEFF;
    writeDesc(1, mkDesc(1, 1, 5, 2, 3));
    runPacket(4, 32, 32, 4'b0010, "R6 overlap order");

    // R5: header absent, then disabled descriptor
    runPacket(4, 32, 32, 4'b0000, "R5 header absent");
    writeDesc(0, mkDesc(0, 1, 3, 4, 2));
    runPacket(4, 32, 32, 4'b0010, "R5 descriptor disabled");

    // R7: length clamps
    runPacket(2, 16, 0, 4'b0010, "R7 zero length");
    runPacket(10, 80, 300, 4'b0010, "R7 R2 length above buffer");

    // R2: short original length
    runPacket(3, 13, 24, 4'b0000, "R2 bytes past metaLen");

    // R4: field running past the buffer end
    clearDescs();
    hdrOffM[2] = 8'd60;
    slotM[5] = 32'hCAFEF00D;
    writeDesc(2, mkDesc(1, 2, 2, 4, 5));
    runPacket(8, 64, 64, 4'b0100, "R4 field clipped at buffer end");

    // random mix
    for (int t = 0; t < 60; t++) begin
      int nc, ml, pl;
      for (int h = 0; h < NH; h++) hdrOffM[h] = 8'($urandom % 40);
      for (int s = 1; s < 8; s++) slotM[s] = $urandom;
      for (int d = 0; d < ND; d++)
        writeDesc(d, mkDesc(($urandom % 4) != 0, int'($urandom % 4), int'($urandom % 24),
                            int'($urandom % 4) + 1, int'($urandom % 8)));
      nc = int'($urandom % 9) + 1;
      ml = int'($urandom % 72);
      case ($urandom % 8)
        0:       pl = 0;
        1:       pl = 64 + int'($urandom % 200);
        default: pl = int'($urandom % 64) + 1;
      endcase
      runPacket(nc, ml, pl, 4'($urandom), "R4 R6 random field data");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule